// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block steers CPU memory accesses that fall in the legacy firmware area between 0xC0000 and 0xFFFFF. Seven byte-wide attribute registers are reached through a plain byte-addressed configuration port. Together they hold fourteen 4-bit fields, and each field governs one address segment. Within a field, one bit decides where reads go and another bit decides where writes go. Each of those bits picks either DRAM or the ROM/forwarded side. Firmware can therefore run from ROM while copying itself into the DRAM underneath: reads come from ROM and writes land in DRAM. Once the copy is done, setting both enables runs the firmware from DRAM.

Memory requests arrive on a valid/ready stream and leave as a registered routing decision on a second valid/ready stream. The decision carries one DRAM-select and one ROM-select strobe, plus a firmware flag. Any read or write in the 64 KiB window just below 4 GiB always goes to the firmware ROM. A ROM-routed access to the top 64 KiB of the first megabyte is flagged as firmware too, and in both windows it carries the same 16-bit byte offset, so the two windows alias each other. Every address outside these ranges goes to DRAM.

Back-pressure: `req_ready` is high whenever the output stage is empty or the consumer takes the held response in the same cycle. A response held while `rsp_ready` is low keeps all of its fields stable.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, all seven attribute registers read 0x00, so every access to 0xC0000–0xFFFFF is routed to the ROM side.
- R2: The attribute registers are at configuration offsets 0x59 to 0x5F, one byte each, and `cfg_rdata` returns the addressed byte. Any other offset reads 0x00, and a write to it has no effect.
- R3: Field n is held in register 0x59 + n/2: bits [3:0] when n is even, bits [7:4] when n is odd. A configuration write changes only the addressed byte.
- R4: Bit 0 of a field sends reads of its segment to DRAM, and bit 1 sends writes to DRAM. When the relevant bit is clear, the access goes to ROM. Bits 3:2 of a field have no effect.
- R5: Field 1 covers 0xF0000–0xFFFFF. Fields 2–9 cover the 16 KiB segments from 0xC0000 to 0xDFFFF in ascending order, and fields 10–13 cover those from 0xE0000 to 0xEFFFF in ascending order.
- R6: Field 0 maps no memory, and its value changes no routing.
- R7: Every access to 0xFFFF0000–0xFFFFFFFF goes to ROM with `rsp_fw_sel` set. A ROM-routed access in 0xF0000–0xFFFFF also sets `rsp_fw_sel`. `rsp_rom_off` equals address bits [15:0].
- R8: Accesses below 0xC0000, between 1 MiB and 0xFFFF0000, and outside the high window go to DRAM, whatever the fields hold.
- R9: The response appears in the cycle after the request handshake. While `rsp_valid` is high, exactly one of `rsp_dram_sel` and `rsp_rom_sel` is set, and `rsp_addr` and `rsp_write` echo the request. With `rsp_ready` held high, one request is accepted every cycle.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response fields stay unchanged.
- R11: A configuration write applies to requests accepted in later cycles. A request accepted in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Byte at cfg_addr |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_addr | output | 32 | Echoed address |
| rsp_write | output | 1 | Echoed direction |
| rsp_dram_sel | output | 1 | Access goes to DRAM |
| rsp_rom_sel | output | 1 | Access goes to ROM/forwarded side |
| rsp_fw_sel | output | 1 | Access hits the firmware ROM image |
| rsp_rom_off | output | 16 | Byte offset into the firmware image |

## Verification
The bench builds the block with its default parameters: a 32-bit address, seven attribute registers at base offset 0x59, and a 16-bit firmware offset. With these values the full register map and all fourteen fields can be reached. Both the low alias and the high firmware window fall inside the address space, so one address model covers every segment edge, the alias offsets and the DRAM fall-through ranges. Random attribute bytes, mixed with random addresses biased toward the shadow area, exercise the read/write split of every field.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int ATTR_BITS = 4;
  localparam int EN_BITS   = 2;
  localparam int RD_EN_BIT = 0;
  localparam int WR_EN_BIT = 1;

  typedef struct packed {
    logic legacy_hit;
    logic high_hit;
    logic [3:0] field_idx;
  } seg_info_t;
endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs #(
  parameter int CFG_AW = 8,
  parameter int NREG = 7,
  parameter logic [CFG_AW-1:0] CFG_BASE = 8'h59,
  localparam int NFIELD = 2 * NREG,
  localparam int EN_W = NFIELD * shadow_pkg::EN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [EN_W-1:0]   attr_en
);
  logic [7:0] regs [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [CFG_AW-1:0] MY_ADDR = CFG_BASE + CFG_AW'(g);
    assign hit[g] = (cfg_addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= 8'h00;
      else if (cfg_we && hit[g]) regs[g] <= cfg_wdata;
    end

    // Only the low two bits of each nibble steer traffic.
    assign attr_en[4*g +: 2]     = regs[g][1:0];
    assign attr_en[4*g + 2 +: 2] = regs[g][5:4];

    // A write aimed elsewhere leaves this byte alone.
    assert_byte_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !hit[g]) |=> $stable(regs[g]));
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) cfg_rdata = regs[i];
    end
  end

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int ADDR_W = 32,
  localparam int SEG_LSB = 14,
  localparam int HI_W = ADDR_W - SEG_LSB
) (
  input  logic [HI_W-1:0]       seg_addr,
  output shadow_pkg::seg_info_t info
);
  // seg_addr holds address bits [ADDR_W-1:14].
  localparam int MB_BIT = 20 - SEG_LSB;
  localparam int K64_BIT = 16 - SEG_LSB;
  logic below_mb;
  logic [3:0] nib19_16;

  assign below_mb = (seg_addr[HI_W-1:MB_BIT] == '0);
  assign nib19_16 = seg_addr[MB_BIT-1:K64_BIT] == 4'hF ? 4'hF
                  : {seg_addr[MB_BIT-1:MB_BIT-2], 2'b00};

  always_comb begin
    info.legacy_hit = below_mb && (seg_addr[MB_BIT-1:MB_BIT-2] == 2'b11);
    info.high_hit   = (seg_addr[HI_W-1:K64_BIT] == '1);
    if (nib19_16 == 4'hF) info.field_idx = 4'd1;
    else                  info.field_idx = 4'd2 + seg_addr[3:0];
  end
endmodule

// File: rtl/shadow_route_stage.sv
module shadow_route_stage #(
  parameter int ADDR_W = 32,
  parameter int NFIELD = 14,
  parameter int OFF_W = 16,
  localparam int EN_W = NFIELD * shadow_pkg::EN_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  shadow_pkg::seg_info_t info,
  input  logic [EN_W-1:0]       attr_en,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [ADDR_W-1:0]     rsp_addr,
  output logic                  rsp_write,
  output logic                  rsp_dram_sel,
  output logic                  rsp_rom_sel,
  output logic                  rsp_fw_sel,
  output logic [OFF_W-1:0]      rsp_rom_off
);
  logic [shadow_pkg::EN_BITS-1:0] en;
  logic to_dram, fw_hit, fire;

  assign en = attr_en[info.field_idx * shadow_pkg::EN_BITS +: shadow_pkg::EN_BITS];

  always_comb begin
    if (info.high_hit)        to_dram = 1'b0;
    else if (info.legacy_hit) to_dram = req_write ? en[shadow_pkg::WR_EN_BIT]
                                                  : en[shadow_pkg::RD_EN_BIT];
    else                      to_dram = 1'b1;
    fw_hit = info.high_hit || (info.legacy_hit && info.field_idx == 4'd1 && !to_dram);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_addr     <= '0;
      rsp_write    <= 1'b0;
      rsp_dram_sel <= 1'b0;
      rsp_rom_sel  <= 1'b0;
      rsp_fw_sel   <= 1'b0;
      rsp_rom_off  <= '0;
    end else if (req_ready) begin
      rsp_valid    <= req_valid;
      rsp_addr     <= req_addr;
      rsp_write    <= req_write;
      rsp_dram_sel <= req_valid && to_dram;
      rsp_rom_sel  <= req_valid && !to_dram;
      rsp_fw_sel   <= req_valid && fw_hit;
      rsp_rom_off  <= req_addr[OFF_W-1:0];
    end
  end

  assert_accept_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid && rsp_addr == $past(req_addr));

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr)
      && $stable(rsp_dram_sel) && $stable(rsp_rom_sel) && $stable(rsp_fw_sel));

  assert_high_window_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && info.high_hit) |=> rsp_rom_sel && rsp_fw_sel
      && rsp_rom_off == $past(req_addr[OFF_W-1:0]));

  assert_outside_dram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !info.high_hit && !info.legacy_hit) |=> rsp_dram_sel && !rsp_rom_sel);

  assert_cleared_field_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && info.legacy_hit && en == '0) |=> rsp_rom_sel && !rsp_dram_sel);
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 8,
  parameter int NREG = 7,
  parameter logic [CFG_AW-1:0] CFG_BASE = 8'h59,
  parameter int OFF_W = 16,
  localparam int NFIELD = 2 * NREG,
  localparam int EN_W = NFIELD * shadow_pkg::EN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_write,
  output logic              rsp_dram_sel,
  output logic              rsp_rom_sel,
  output logic              rsp_fw_sel,
  output logic [OFF_W-1:0]  rsp_rom_off
);
  logic [EN_W-1:0] attr_en;
  shadow_pkg::seg_info_t info;

  shadow_attr_regs #(.CFG_AW(CFG_AW), .NREG(NREG), .CFG_BASE(CFG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_en(attr_en)
  );

  shadow_seg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .seg_addr(req_addr[ADDR_W-1:14]), .info(info)
  );

  shadow_route_stage #(.ADDR_W(ADDR_W), .NFIELD(NFIELD), .OFF_W(OFF_W)) u_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .info(info), .attr_en(attr_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_write(rsp_write), .rsp_dram_sel(rsp_dram_sel), .rsp_rom_sel(rsp_rom_sel),
    .rsp_fw_sel(rsp_fw_sel), .rsp_rom_off(rsp_rom_off)
  );
endmodule

// File: tb/shadow_attr_decoder_bench.sv
module shadow_attr_decoder_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0, rsp_addr;
  logic rsp_valid, rsp_ready = 1, rsp_write, rsp_dram_sel, rsp_rom_sel, rsp_fw_sel;
  logic [15:0] rsp_rom_off;
  int checks = 0, errors = 0;
  logic [7:0] model [7];

  always #2 clk = ~clk;

  shadow_attr_decoder u_shadow_attr_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_write(rsp_write), .rsp_dram_sel(rsp_dram_sel), .rsp_rom_sel(rsp_rom_sel),
    .rsp_fw_sel(rsp_fw_sel), .rsp_rom_off(rsp_rom_off)
  );

  task automatic check(input string req, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", req, act, exp);
    end
  endtask

  // Field index for an address, -1 if outside the shadow area.
  function automatic int field_of(input logic [31:0] a);
    if (a[31:20] != 0 || a[19:18] != 2'b11) return -1;
    if (a[19:16] == 4'hF) return 1;
    return 2 + int'(a[17:14]);
  endfunction

  function automatic void expect_route(input logic [31:0] a, input logic w,
                                       output bit dram, output bit fw);
    int f = field_of(a);
    logic [3:0] nib;
    if (a[31:16] == 16'hFFFF) begin dram = 0; fw = 1; return; end
    if (f < 0) begin dram = 1; fw = 0; return; end
    nib = f[0] ? model[f/2][7:4] : model[f/2][3:0];
    dram = w ? nib[1] : nib[0];
    fw = (f == 1) && !dram;
  endfunction

  function automatic string rsp_str();
    return $sformatf("v=%0b d=%0b r=%0b fw=%0b off=%h a=%h w=%0b", rsp_valid,
      rsp_dram_sel, rsp_rom_sel, rsp_fw_sel, rsp_rom_off, rsp_addr, rsp_write);
  endfunction

  function automatic bit rsp_ok(input logic [31:0] a, input logic w, input bit d, input bit f);
    return rsp_valid && rsp_dram_sel == d && rsp_rom_sel == !d && rsp_fw_sel == f
      && rsp_rom_off == a[15:0] && rsp_addr == a && rsp_write == w;
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a >= 8'h59 && a <= 8'h5F) model[a - 8'h59] = d;
  endtask

  task automatic cfg_expect(input string req, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk); cfg_addr = a; #1;
    check(req, cfg_rdata == e, $sformatf("rd[%h]=%h", a, cfg_rdata), $sformatf("%h", e));
  endtask

  task automatic issue(input string req, input logic [31:0] a, input logic w);
    bit d, f;
    expect_route(a, w, d, f);
    @(negedge clk); req_valid = 1; req_addr = a; req_write = w;
    @(negedge clk); req_valid = 0;
    check(req, rsp_ok(a, w, d, f), rsp_str(),
          $sformatf("d=%0b fw=%0b a=%h w=%0b", d, f, a, w));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit d, f;
    logic [31:0] a;
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int i = 0; i < 7; i++) cfg_expect("R1", 8'h59 + 8'(i), 8'h00);
    check("R1", !rsp_valid && req_ready, rsp_str(), "idle");
    issue("R1", 32'h000F_1234, 0);
    issue("R1", 32'h000C_0000, 1);

    // R2: map bounds, stray offsets
    cfg_write(8'h58, 8'hFF); cfg_write(8'h60, 8'hFF);
    cfg_expect("R2", 8'h58, 8'h00); cfg_expect("R2", 8'h60, 8'h00);
    cfg_expect("R2", 8'h59, 8'h00); cfg_expect("R2", 8'h5F, 8'h00);
    cfg_write(8'h5F, 8'hA5); cfg_expect("R2", 8'h5F, 8'hA5);

    // R3: nibble placement and byte isolation
    cfg_write(8'h5C, 8'h21);
    cfg_expect("R3", 8'h5C, 8'h21); cfg_expect("R3", 8'h5B, 8'h00);
    cfg_expect("R3", 8'h5D, 8'h00);
    issue("R3", 32'h000D_0010, 0); issue("R3", 32'h000D_0010, 1);
    issue("R3", 32'h000D_4020, 0); issue("R3", 32'h000D_4020, 1);
    issue("R3", 32'h000D_8000, 0);

    // R4: bits 3:2 ignored
    cfg_write(8'h5A, 8'h0C);
    issue("R4", 32'h000C_0000, 0); issue("R4", 32'h000C_3FFF, 1);
    cfg_write(8'h5A, 8'h03);
    issue("R4", 32'h000C_3FFF, 0); issue("R4", 32'h000C_0000, 1);

    // R6: field 0 has no effect
    cfg_write(8'h59, 8'h0F);
    issue("R6", 32'h000F_0000, 0); issue("R6", 32'h000F_FFFF, 1);
    issue("R6", 32'h000E_0000, 0);

    // R5: segment sweep, one field enabled at a time
    for (int n = 1; n < 14; n++) begin
      for (int r = 0; r < 7; r++) cfg_write(8'h59 + 8'(r), 8'h00);
      cfg_write(8'h59 + 8'(n / 2), (n % 2) ? 8'h30 : 8'h03);
      for (int s = 1; s < 14; s++) begin
        a = (s == 1) ? 32'h000F_0000 : 32'h000C_0000 + 32'((s - 2) * 32'h4000);
        issue("R5", a, 0);
        issue("R5", a + ((s == 1) ? 32'hFFFF : 32'h3FFF), 1);
      end
    end

    // R7: high window and alias offsets
    for (int r = 0; r < 7; r++) cfg_write(8'h59 + 8'(r), 8'hFF);
    issue("R7", 32'hFFFF_0000, 0); issue("R7", 32'hFFFF_ABCD, 1);
    issue("R7", 32'hFFFF_FFFF, 0);
    cfg_write(8'h59, 8'h00);
    issue("R7", 32'h000F_ABCD, 0);

    // R8: DRAM fall-through regardless of fields
    issue("R8", 32'h000B_FFFF, 0); issue("R8", 32'h0010_0000, 1);
    issue("R8", 32'hFFFE_FFFF, 0); issue("R8", 32'h0000_0000, 1);

    // R11: write and request in the same cycle
    cfg_write(8'h59, 8'h00);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h59; cfg_wdata = 8'h10;
    req_valid = 1; req_addr = 32'h000F_0040; req_write = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0; model[0] = 8'h10;
    check("R11", rsp_ok(32'h000F_0040, 0, 0, 1), rsp_str(), "old value: rom");
    issue("R11", 32'h000F_0040, 0);

    // R9: back-to-back throughput
    expect_route(32'h000F_0001, 0, d, f);
    @(negedge clk); req_valid = 1; req_addr = 32'h000F_0001; req_write = 0;
    @(negedge clk);
    check("R9", rsp_ok(32'h000F_0001, 0, d, f) && req_ready, rsp_str(), "first of pair");
    expect_route(32'h0020_0000, 1, d, f);
    req_addr = 32'h0020_0000; req_write = 1;
    @(negedge clk); req_valid = 0;
    check("R9", rsp_ok(32'h0020_0000, 1, d, f), rsp_str(), "second of pair");

    // R10: back-pressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_addr = 32'hFFFF_1111; req_write = 0;
    @(negedge clk); req_addr = 32'h0000_5000; req_write = 1;
    check("R10", rsp_ok(32'hFFFF_1111, 0, 0, 1) && !req_ready, rsp_str(), "A held");
    @(negedge clk);
    check("R10", rsp_ok(32'hFFFF_1111, 0, 0, 1) && !req_ready, rsp_str(), "A still held");
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    check("R10", rsp_ok(32'h0000_5000, 1, 1, 0), rsp_str(), "B after release");
    @(negedge clk);
    check("R9", !rsp_valid && !rsp_dram_sel && !rsp_rom_sel, rsp_str(), "idle");

    // Random mix
    void'($urandom(32'h5EED));
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 3) == 0) cfg_write(8'h59 + 8'($urandom_range(0, 6)), 8'($urandom));
      case ($urandom_range(0, 3))
        0, 1: a = 32'h000C_0000 + 32'($urandom_range(0, 32'h3FFFF));
        2:    a = 32'hFFFF_0000 + 32'($urandom_range(0, 32'hFFFF));
        default: a = $urandom;
      endcase
      issue("R4", a, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule